// File: doc/BRIEF.md
# Dual Cadence Timer with Interrupts

This block switches two tone generators on and off in a repeating on/off pattern. Each generator has two programmable intervals. The on interval sets how long its gate output stays high. The off interval sets how long the gate stays low before the pattern starts again. Both intervals are counted in ticks of the sample-rate strobe. When the end of an interval is reached, the gate changes level and a pending flag is raised for that interval. The pending flags are masked by an enable register and then combined into a single interrupt request line.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational. The port holds a four-bit interrupt-enable register, a four-bit pending register that is cleared by writing one to a bit, and four 16-bit interval registers. Each generator starts running when its oscillator-enable input is driven high. The waveform that the gate controls is produced outside this block.

Top module: `cadence_irq_unit`

## Requirements
- R1: After reset, both gates are low, irq is low, and every register reads zero.
- R2: The register map is as follows. Address 0 is the interrupt-enable register and address 1 is the pending register. Both use the same bit order: bit0 = generator 0 on interval, bit1 = generator 0 off interval, bit2 = generator 1 on interval, bit3 = generator 1 off interval. Addresses 2, 3, 4 and 5 hold the interval lengths for generator 0 on, generator 0 off, generator 1 on and generator 1 off. Bits above bit 3 of addresses 0 and 1 read as zero.
- R3: The gate goes high in the cycle after the clock edge at which osc_en is first sampled high. It then stays high for exactly the programmed number of on-interval ticks.
- R4: At the edge that counts the last on tick, the gate goes low and the on pending bit is set. After the programmed number of off-interval ticks, the gate goes high again and the off pending bit is set.
- R5: The timers advance only on cycles where tick is high. With tick low, the gate holds its level.
- R6: If either interval of a generator is zero, its gate stays high for as long as osc_en is high, and that generator sets no pending bits.
- R7: A pending bit is set by its event even when its enable bit is clear. irq is the OR over all four bits of (pending AND enable).
- R8: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R9: If a clear of a pending bit and a new event for that bit fall in the same cycle, the bit stays set.
- R10: Driving osc_en low forces the gate low at the next edge and resets both timers of that generator. The next enable then starts a full on interval.
- R11: The two generators run independently. One generator's activity never moves the other generator's gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate strobe, one cycle wide |
| osc_en | input | 2 | Oscillator enable, one bit per generator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| gate | output | 2 | Gate output, one bit per generator |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs interval pairs of length one, where the on and off edges fall in back-to-back cycles. An off-by-one in the terminal count would show up there as a gate that is one tick too long or too short. A clear write is timed so that it lands on the same edge as an expiry event. A design that gives the clear priority would lose that interrupt. A generator is disabled in the middle of its on interval and then re-enabled. A design that keeps the old count would end the next on interval early. The bench also holds tick low and programs zero-length intervals. A design that counts clock cycles instead of ticks, or that cycles when an interval is zero, would drop the gate when it should not.

// File: rtl/cadence_pkg.sv
package cadence_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;

  localparam int ADDR_W = 3;
  localparam int A_IEN  = 0;
  localparam int A_PEND = 1;
  localparam int A_DUR0 = 2;

endpackage

// File: rtl/cadence_seq.sv
module cadence_seq
  import cadence_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             osc_en,
  input  logic [DUR_W-1:0] on_len,
  input  logic [DUR_W-1:0] off_len,
  output logic             gate,
  output logic             on_evt,
  output logic             off_evt
);

  phase_t           ph_q, ph_n;
  logic [DUR_W-1:0] cnt_q, cnt_n;
  logic             no_cadence;

  assign no_cadence = (on_len == '0) || (off_len == '0);
  assign gate       = (ph_q == PH_ON);

  always_comb begin
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    on_evt  = 1'b0;
    off_evt = 1'b0;
    if (!osc_en) begin
      ph_n  = PH_IDLE;
      cnt_n = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          ph_n  = PH_ON;
          cnt_n = '0;
        end
        PH_ON: begin
          if (tick && !no_cadence) begin
            if (cnt_q >= on_len - DUR_W'(1)) begin
              on_evt = 1'b1;
              ph_n   = PH_OFF;
              cnt_n  = '0;
            end else begin
              cnt_n = cnt_q + DUR_W'(1);
            end
          end
        end
        PH_OFF: begin
          if (no_cadence) begin
            ph_n  = PH_ON;
            cnt_n = '0;
          end else if (tick) begin
            if (cnt_q >= off_len - DUR_W'(1)) begin
              off_evt = 1'b1;
              ph_n    = PH_ON;
              cnt_n   = '0;
            end else begin
              cnt_n = cnt_q + DUR_W'(1);
            end
          end
        end
        default: begin
          ph_n  = PH_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  assert_gate_off_after_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !gate);

  assert_no_event_without_cadence_R6: assert property (@(posedge clk) disable iff (!rst_n)
    no_cadence |-> (!on_evt && !off_evt));

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !tick && gate) |=> gate);

  assert_on_expiry_drops_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |=> !gate);

endmodule

// File: rtl/cadence_regs.sv
module cadence_regs
  import cadence_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int DUR_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DUR_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DUR_W-1:0]             rd_data,
  input  logic [2*NUM_GEN-1:0]         evt,
  output logic [2*NUM_GEN-1:0][DUR_W-1:0] dur,
  output logic                         irq
);

  localparam int NT = 2 * NUM_GEN;

  logic [NT-1:0] ien_q, pend_q, pend_n, clr;
  logic          ien_we, pend_we;

  assign ien_we  = wr_en && (wr_addr == ADDR_W'(A_IEN));
  assign pend_we = wr_en && (wr_addr == ADDR_W'(A_PEND));
  assign clr     = pend_we ? wr_data[NT-1:0] : '0;
  assign pend_n  = (pend_q & ~clr) | evt;
  assign irq     = |(pend_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= wr_data[NT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_dur
    logic dur_we;
    assign dur_we = wr_en && (wr_addr == ADDR_W'(A_DUR0 + t));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dur[t] <= '0;
      end else if (dur_we) begin
        dur[t] <= wr_data;
      end
    end

    assert_event_sets_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt[t] |=> pend_q[t]);

    assert_clear_drops_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_we && wr_data[t] && !evt[t]) |=> !pend_q[t]);
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_IEN)) begin
      rd_data = DUR_W'(ien_q);
    end else if (rd_addr == ADDR_W'(A_PEND)) begin
      rd_data = DUR_W'(pend_q);
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (rd_addr == ADDR_W'(A_DUR0 + t)) rd_data = dur[t];
      end
    end
  end

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

endmodule

// File: rtl/cadence_irq_unit.sv
module cadence_irq_unit
  import cadence_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int DUR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [NUM_GEN-1:0] osc_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DUR_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DUR_W-1:0]   rd_data,
  output logic [NUM_GEN-1:0] gate,
  output logic               irq
);

  localparam int NT = 2 * NUM_GEN;

  logic [1:0]                   rst_sync_q;
  logic                         core_rst_n;
  logic [NT-1:0]                evt;
  logic [NT-1:0][DUR_W-1:0]     dur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  cadence_regs #(.NUM_GEN(NUM_GEN), .DUR_W(DUR_W)) u_regs (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .evt     (evt),
    .dur     (dur),
    .irq     (irq)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    cadence_seq #(.DUR_W(DUR_W)) u_seq (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .tick    (tick),
      .osc_en  (osc_en[g]),
      .on_len  (dur[2*g]),
      .off_len (dur[2*g+1]),
      .gate    (gate[g]),
      .on_evt  (evt[2*g]),
      .off_evt (evt[2*g+1])
    );
  end

  assert_gate_low_in_reset_R1: assert property (@(posedge clk)
    !core_rst_n |=> (gate == '0));

endmodule

// File: tb/sim_cadence_irq_unit.sv
`timescale 1ns/1ps
module sim_cadence_irq_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [1:0]  osc_en;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  gate;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cadence_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_en(osc_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate(gate), .irq(irq)
  );

  // {generator, on ticks, off ticks}
  localparam int VEC [6][3] = '{
    '{0, 1, 1}, '{0, 3, 2}, '{1, 5, 7}, '{1, 2, 4}, '{0, 4, 1}, '{1, 1, 3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; tick = 1'b1; osc_en = 2'b00;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 gate", gate, 0);
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reg", v, 0);
    end

    // R2 map and readback
    wr(0, 16'h00A5); rd(0, v); chk("R2 enable width", v, 16'h0005);
    wr(2, 16'h1234); rd(2, v); chk("R2 dur g0 on", v, 16'h1234);
    wr(5, 16'hBEEF); rd(5, v); chk("R2 dur g1 off", v, 16'hBEEF);
    wr(0, 16'h0000);

    // Table walk: R3, R4, R7, R11
    for (int i = 0; i < 6; i++) begin
      int g = VEC[i][0];
      int na = VEC[i][1];
      int ni = VEC[i][2];
      wr(3'(2 + 2*g), 16'(na));
      wr(3'(3 + 2*g), 16'(ni));
      wr(1, 16'h000F);
      wr(0, 16'h000F);
      rd_addr = 3'd1;
      osc_en[g] = 1'b1;
      for (int k = 0; k <= na + ni; k++) begin
        step();
        if (k == na - 1) begin
          chk("R3 gate on through interval", gate[g], 1);
          chk("R3 on pending not yet", rd_data[2*g], 0);
        end
        if (k == na) begin
          chk("R4 gate off at on expiry", gate[g], 0);
          chk("R4 on pending set", rd_data[2*g], 1);
          chk("R7 irq raised", irq, 1);
          chk("R11 other gate idle", gate[1-g], 0);
        end
        if (k == na + ni - 1) begin
          chk("R4 gate off through off interval", gate[g], 0);
          chk("R4 off pending not yet", rd_data[2*g+1], 0);
        end
        if (k == na + ni) begin
          chk("R4 gate back on", gate[g], 1);
          chk("R4 off pending set", rd_data[2*g+1], 1);
        end
      end
      osc_en[g] = 1'b0;
      step();
    end
    wr(0, 16'h0000);
    wr(1, 16'h000F);

    // R5: no tick, no progress
    wr(2, 16'd2); wr(3, 16'd2);
    tick = 1'b0;
    osc_en[0] = 1'b1;
    step();
    chk("R5 starts on without tick", gate[0], 1);
    repeat (6) step();
    chk("R5 held without tick", gate[0], 1);
    rd(1, v); chk("R5 no pending without tick", v, 0);
    tick = 1'b1;
    step();
    chk("R5 one tick not enough", gate[0], 1);
    step();
    chk("R5 second tick expires", gate[0], 0);
    osc_en[0] = 1'b0; step();
    wr(1, 16'h000F);

    // R6: zero length interval
    wr(4, 16'd0); wr(5, 16'd5);
    osc_en[1] = 1'b1;
    repeat (20) step();
    chk("R6 zero on interval keeps gate", gate[1], 1);
    rd(1, v); chk("R6 no pending", v, 0);
    wr(4, 16'd5); wr(5, 16'd0);
    repeat (20) step();
    chk("R6 zero off interval keeps gate", gate[1], 1);
    rd(1, v); chk("R6 no pending", v, 0);
    osc_en[1] = 1'b0; step();

    // R7: pending without enable; masking
    wr(0, 16'h0000);
    wr(2, 16'd1); wr(3, 16'd50);
    osc_en[0] = 1'b1;
    step(); step();
    rd(1, v); chk("R7 pending set while masked", v[0], 1);
    chk("R7 irq masked", irq, 0);
    osc_en[0] = 1'b0;
    wr(0, 16'h0002);
    chk("R7 other enable only", irq, 0);
    wr(0, 16'h0001);
    chk("R7 enabled pending drives irq", irq, 1);

    // R8: write one clears, zero keeps
    wr(1, 16'h0000);
    rd(1, v); chk("R8 write zero keeps", v[0], 1);
    wr(1, 16'h0001);
    rd(1, v); chk("R8 write one clears", v[0], 0);
    chk("R8 irq drops", irq, 0);

    // R9: clear and event in the same cycle
    wr(2, 16'd3); wr(3, 16'd10);
    osc_en[0] = 1'b1;
    step(); step(); step();
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0001;
    step();
    wr_en = 1'b0;
    rd(1, v); chk("R9 event beats clear", v[0], 1);
    chk("R9 gate off at expiry", gate[0], 0);
    osc_en[0] = 1'b0; step();
    wr(1, 16'h000F);

    // R10: disable mid interval restarts
    wr(2, 16'd5); wr(3, 16'd5);
    osc_en[0] = 1'b1;
    step(); step(); step();
    osc_en[0] = 1'b0;
    step();
    chk("R10 gate off after disable", gate[0], 0);
    osc_en[0] = 1'b1;
    for (int k = 0; k <= 5; k++) begin
      step();
      if (k == 4) begin
        chk("R10 full on interval after restart", gate[0], 1);
        rd(1, v); chk("R10 no early expiry", v[0], 0);
      end
      if (k == 5) chk("R10 expiry after full interval", gate[0], 0);
    end
    osc_en[0] = 1'b0; step();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule